// File: doc/BRIEF.md
# External Clock Failure Monitor

This block watches an external oscillator clock and declares it failed when it stops toggling. The check runs in the domain of an internal reference clock that never stops. A toggle flop clocked by the external clock is carried into the reference domain through a short synchronizer chain. Each change of the synchronized toggle restarts a silence counter. If the counter reaches a programmable limit, the block declares a failure.

Monitoring runs only while software has set the enable bit and the oscillator reports that it is both switched on and ready, which means its startup delay is over. Switching the oscillator off disarms the detector and throws away any partial count.

On a failure the block sends a one-cycle event to the timer break inputs. It also sets a sticky pending flag that is wired as a non-maskable interrupt, forces the oscillator off, and, if the oscillator was feeding the system clock, asks the clock switch to fall back to another source. The pending flag, the forced disable and the fallback request all stay set until software writes the clear strobe.

Top module: `clkFailMonitor`

## Requirements
- R1: Out of reset, breakPulse, nmiPending, oscForceOff and clkFallbackReq are all low.
- R2: No failure is declared unless monEnable, oscOn and oscReady are all high.
- R3: When the monitor is armed and the external clock is stopped, breakPulse is high after the TIMEOUT_CYCLES-th reference rising edge counted from the first armed edge (default 8), and is low before that edge.
- R4: An external clock that keeps toggling (for example with a period of 1.5 reference periods) never causes a failure.
- R5: breakPulse lasts exactly one reference cycle. A single stoppage produces only one pulse for as long as the monitor stays armed.
- R6: nmiPending goes high together with breakPulse and stays high until a cycle in which pendClear is high. It is low in the cycle after that one.
- R7: If pendClear is high in the same cycle that a new failure is detected, nmiPending is left set.
- R8: oscForceOff is set on a failure and is cleared by pendClear, following the same rule as nmiPending.
- R9: clkFallbackReq is set on a failure only if sysClkFromExt is high when the failure is detected. It is cleared by pendClear.
- R10: Dropping oscOn for one cycle during a count discards the count. After oscOn returns, a full TIMEOUT_CYCLES of silence is needed before a failure is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Always-running internal reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extClk | input | 1 | Monitored external oscillator clock |
| monEnable | input | 1 | Software enable for monitoring |
| oscOn | input | 1 | External oscillator switched on |
| oscReady | input | 1 | External oscillator startup delay finished |
| sysClkFromExt | input | 1 | External oscillator currently drives the system clock, directly or through the PLL |
| pendClear | input | 1 | Software strobe that clears the pending flag |
| breakPulse | output | 1 | One-cycle failure event to the timer break inputs |
| nmiPending | output | 1 | Sticky failure flag, wired as a non-maskable interrupt |
| oscForceOff | output | 1 | Forces the external oscillator off |
| clkFallbackReq | output | 1 | Asks the system clock switch to leave the external source |

## Verification
The assertions assume that the arming inputs and pendClear are synchronous to refClk. They also assume that extClk is either stopped or toggling well inside the limit, so the synchronizer sees an edge at least every few reference cycles.

The stimulus changes every control input only on falling reference edges. Each arming scenario starts after at least six quiet cycles, so no stale toggle is still in flight when the count begins. The running external clock has a period of 1.5 reference cycles, far inside the default limit of eight cycles.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // strobes from control to the silence counter
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntStrobe_t;
endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       extClk,
  input  cntStrobe_t strobe,
  output logic       edgeSeen,
  output logic       cntAtLast,
  output logic       cntSat
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(TIMEOUT_CYCLES);

  logic extToggle;
  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0] silenceCnt;

  // toggle in the monitored domain
  always_ff @(posedge extClk or negedge rstN) begin
    if (!rstN) extToggle <= 1'b0;
    else       extToggle <= ~extToggle;
  end

  // synchronizer stages plus one history stage for edge detection
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], extToggle};
  end

  assign edgeSeen = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                silenceCnt <= '0;
    else if (strobe.cntClear) silenceCnt <= '0;
    else if (strobe.cntInc)   silenceCnt <= silenceCnt + 1'b1;
  end

  assign cntAtLast = (silenceCnt == LAST);
  assign cntSat    = (silenceCnt == SAT);

  AST_CNT_BOUND: assert property (@(posedge refClk) disable iff (!rstN)
    silenceCnt <= SAT); // R5
  AST_EDGE_RESTARTS: assert property (@(posedge refClk) disable iff (!rstN)
    edgeSeen |=> (silenceCnt == '0)); // R4
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic       monEnable,
  input  logic       oscOn,
  input  logic       oscReady,
  input  logic       sysClkFromExt,
  input  logic       pendClear,
  input  logic       edgeSeen,
  input  logic       cntAtLast,
  input  logic       cntSat,
  output cntStrobe_t strobe,
  output logic       breakPulse,
  output logic       nmiPending,
  output logic       oscForceOff,
  output logic       clkFallbackReq
);
  logic armed;
  logic failNow;

  assign armed   = monEnable & oscOn & oscReady;
  assign failNow = armed & ~edgeSeen & cntAtLast;

  always_comb begin
    strobe.cntClear = ~armed | edgeSeen;
    strobe.cntInc   = ~strobe.cntClear & ~cntSat;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      breakPulse     <= 1'b0;
      nmiPending     <= 1'b0;
      oscForceOff    <= 1'b0;
      clkFallbackReq <= 1'b0;
    end else begin
      breakPulse     <= failNow;
      nmiPending     <= failNow | (nmiPending & ~pendClear);
      oscForceOff    <= failNow | (oscForceOff & ~pendClear);
      clkFallbackReq <= (failNow & sysClkFromExt) | (clkFallbackReq & ~pendClear);
    end
  end

  AST_BREAK_ONE_CYCLE: assert property (@(posedge refClk) disable iff (!rstN)
    breakPulse |=> !breakPulse); // R5
  AST_BREAK_NEEDS_ARM: assert property (@(posedge refClk) disable iff (!rstN)
    !armed |=> !breakPulse); // R2
  AST_PEND_WITH_BREAK: assert property (@(posedge refClk) disable iff (!rstN)
    breakPulse |-> (nmiPending && oscForceOff)); // R6
  AST_PEND_STICKY: assert property (@(posedge refClk) disable iff (!rstN)
    (nmiPending && !pendClear) |=> nmiPending); // R6
  AST_CLEAR_LOSES: assert property (@(posedge refClk) disable iff (!rstN)
    (failNow && pendClear) |=> nmiPending); // R7
  AST_FALLBACK_GATED: assert property (@(posedge refClk) disable iff (!rstN)
    (!clkFallbackReq && !sysClkFromExt) |=> !clkFallbackReq); // R9
endmodule

// File: rtl/clkFailMonitor.sv
module clkFailMonitor
  import clkmon_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic rstN,
  input  logic extClk,
  input  logic monEnable,
  input  logic oscOn,
  input  logic oscReady,
  input  logic sysClkFromExt,
  input  logic pendClear,
  output logic breakPulse,
  output logic nmiPending,
  output logic oscForceOff,
  output logic clkFallbackReq
);
  cntStrobe_t strobe;
  logic edgeSeen;
  logic cntAtLast;
  logic cntSat;

  clkmon_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp (
    .refClk(refClk),
    .rstN(rstN),
    .extClk(extClk),
    .strobe(strobe),
    .edgeSeen(edgeSeen),
    .cntAtLast(cntAtLast),
    .cntSat(cntSat)
  );

  clkmon_ctrl ctl (
    .refClk(refClk),
    .rstN(rstN),
    .monEnable(monEnable),
    .oscOn(oscOn),
    .oscReady(oscReady),
    .sysClkFromExt(sysClkFromExt),
    .pendClear(pendClear),
    .edgeSeen(edgeSeen),
    .cntAtLast(cntAtLast),
    .cntSat(cntSat),
    .strobe(strobe),
    .breakPulse(breakPulse),
    .nmiPending(nmiPending),
    .oscForceOff(oscForceOff),
    .clkFallbackReq(clkFallbackReq)
  );

  AST_FORCE_OFF_ON_BREAK: assert property (@(posedge refClk) disable iff (!rstN)
    breakPulse |-> oscForceOff); // R8
endmodule

// File: tb/clkFailMonitor_test.sv
module clkFailMonitor_test;
  localparam int T = 8;
  // vector bits: enable, oscOn, oscReady, extRunning, sysClkFromExt
  localparam logic [4:0] VEC [0:7] = '{
    5'b11100, 5'b11101, 5'b11110, 5'b01101,
    5'b10101, 5'b11001, 5'b11111, 5'b00000
  };

  logic refClk = 1'b0;
  logic extClk = 1'b0;
  logic extRun = 1'b0;
  logic rstN = 1'b0;
  logic monEnable = 1'b0, oscOn = 1'b0, oscReady = 1'b0;
  logic sysClkFromExt = 1'b0, pendClear = 1'b0;
  logic breakPulse, nmiPending, oscForceOff, clkFallbackReq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 refClk = ~refClk;
  always #15 if (extRun) extClk = ~extClk;

  clkFailMonitor #(.TIMEOUT_CYCLES(T)) uut (
    .refClk(refClk), .rstN(rstN), .extClk(extClk),
    .monEnable(monEnable), .oscOn(oscOn), .oscReady(oscReady),
    .sysClkFromExt(sysClkFromExt), .pendClear(pendClear),
    .breakPulse(breakPulse), .nmiPending(nmiPending),
    .oscForceOff(oscForceOff), .clkFallbackReq(clkFallbackReq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge refClk);
  endtask

  task automatic quietAndClear();
    monEnable = 1'b0; oscOn = 1'b0; oscReady = 1'b0; sysClkFromExt = 1'b0;
    tick(6);
    pendClear = 1'b1;
    tick(1);
    pendClear = 1'b0;
  endtask

  task automatic armAll();
    monEnable = 1'b1; oscOn = 1'b1; oscReady = 1'b1;
  endtask

  initial begin
    tick(3);
    chk("R1 breakPulse", breakPulse, 0);
    chk("R1 nmiPending", nmiPending, 0);
    chk("R1 oscForceOff", oscForceOff, 0);
    chk("R1 clkFallbackReq", clkFallbackReq, 0);
    rstN = 1'b1;
    tick(2);

    // scenario table
    for (int i = 0; i < 8; i++) begin
      int breaks;
      int expFail;
      quietAndClear();
      extRun = VEC[i][1];
      tick(6);
      monEnable = VEC[i][4]; oscOn = VEC[i][3]; oscReady = VEC[i][2];
      sysClkFromExt = VEC[i][0];
      expFail = int'(VEC[i][4] & VEC[i][3] & VEC[i][2] & ~VEC[i][1]);
      breaks = 0;
      for (int k = 0; k < 3 * T; k++) begin
        tick(1);
        breaks += int'(breakPulse);
      end
      chk("R2 R4 R5 break count", breaks, expFail);
      chk("R6 pending", nmiPending, expFail);
      chk("R8 forceOff", oscForceOff, expFail);
      chk("R9 fallback", clkFallbackReq, expFail & int'(VEC[i][0]));
    end
    extRun = 1'b0;

    // R3 exact timing and R5 width
    quietAndClear();
    armAll();
    tick(T - 1);
    chk("R3 no break before limit", breakPulse, 0);
    tick(1);
    chk("R3 break at limit", breakPulse, 1);
    chk("R6 pending with break", nmiPending, 1);
    tick(1);
    chk("R5 break one cycle", breakPulse, 0);
    tick(5);
    chk("R6 pending sticky", nmiPending, 1);
    pendClear = 1'b1;
    tick(1);
    pendClear = 1'b0;
    chk("R6 pending cleared", nmiPending, 0);
    chk("R8 forceOff cleared", oscForceOff, 0);

    // R7 clear coincident with failure
    quietAndClear();
    armAll();
    tick(T - 1);
    pendClear = 1'b1;
    tick(1);
    chk("R7 break during clear", breakPulse, 1);
    chk("R7 pending kept", nmiPending, 1);
    pendClear = 1'b0;
    tick(1);
    chk("R7 pending still set", nmiPending, 1);

    // R9 fallback cleared by pendClear
    quietAndClear();
    armAll();
    sysClkFromExt = 1'b1;
    tick(T + 1);
    chk("R9 fallback set", clkFallbackReq, 1);
    monEnable = 1'b0;
    pendClear = 1'b1;
    tick(1);
    pendClear = 1'b0;
    chk("R9 fallback cleared", clkFallbackReq, 0);

    // R10 oscillator off discards the partial count
    quietAndClear();
    armAll();
    tick(T - 2);
    oscOn = 1'b0;
    tick(1);
    oscOn = 1'b1;
    tick(T - 1);
    chk("R10 no early break", breakPulse, 0);
    tick(1);
    chk("R10 break after full count", breakPulse, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule